// File: doc/BRIEF.md
# Rename Stage Flow Control

This block decides, every cycle, how much of an instruction group from decode may pass through the rename stage. A group holds up to W instructions. Each one carries a tag, a destination-register count, a "squashed" flag and a "serializing" flag. The block does not rename registers itself. Its result is the ordered list of tags allowed through this cycle, packed from output slot 0 and given with a count. The register-mapping logic next to it performs the actual renames.

Several limits bound the budget. The reorder-buffer and issue-queue free counts reported by later stages are stale by a feedback delay, so the block first takes W times that delay off each count. The free physical-register count also limits how far the group gets. When the group cannot be finished, the block stalls decode and parks the group in a skid buffer, together with the offset of the first instruction not yet handled. Once the later stages have room again, it resumes from that offset. A squash from commit flushes all held state.

Top module: `rename_flow_ctrl`

## Requirements
- R1: After reset the output count is 0, the decode stall is low and the stage state is RUN (code 0).
- R2: Usable space is computed as reported free count minus W*DLY, separately for the reorder buffer and the issue queue. If the smaller of the two is zero or negative and instructions are available, nothing is sent, the stage enters BLOCKED (code 1) and the group is kept.
- R3: If that minimum is positive but below the number of instructions left in the group, only that many slots are processed. The stage then blocks, and the remaining instructions are sent later starting at the saved offset.
- R4: Sent tags keep group order and are packed from output slot 0; unused output slots read 0. out_cnt_o gives their number. All outputs are registered and reflect the inputs of the previous cycle.
- R5: An instruction flagged squashed is not sent. It still uses one slot of the budget and advances the offset.
- R6: A serializing instruction is sent, and processing of the group then stops. The stage enters BARRIER (code 3) with decode stalled.
- R7: Each instruction needs as many physical registers as its destination count. Processing stops before an instruction whose count exceeds the free-register count minus the registers already taken by earlier instructions in this cycle, and the stage blocks.
- R8: While BLOCKED or BARRIER, nothing is sent, and any non-empty incoming group is appended to the skid buffer.
- R9: BLOCKED or BARRIER moves to UNBLOCK (code 2) only in a cycle where five conditions all hold: no stall from execute, no stall from commit, both usable counts positive, and a non-zero free-register count. In UNBLOCK the front skid group is processed from the saved offset and popped once it is finished. The stage returns to RUN when the skid buffer empties.
- R10: The saved offset returns to 0 after every cycle that ends without a block, so the next group starts at its slot 0.
- R11: A squash overrides all else. Nothing is sent, the skid buffer is emptied, the offset is cleared, decode is not stalled and the state is SQUASH (code 4). The state falls back to RUN in the next cycle without a squash.
- R12: The decode stall output is high exactly when the state is BLOCKED, UNBLOCK or BARRIER.
- R13: The skid buffer is never written while full unless its front is popped in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_cnt_i | input | 3 | Number of valid instructions in the decode group |
| dec_tag_i | input | 24 | Instruction tags, slot i in bits [6i+5:6i] |
| dec_squashed_i | input | 4 | Per-slot squashed flag |
| dec_serial_i | input | 4 | Per-slot serializing flag |
| dec_dst_i | input | 8 | Per-slot destination-register count, slot i in bits [2i+1:2i] |
| rob_free_i | input | 8 | Reorder-buffer free count as reported (delayed) |
| iq_free_i | input | 8 | Issue-queue free count as reported (delayed) |
| prf_free_i | input | 8 | Free physical-register count |
| iew_stall_i | input | 1 | Stall from the execute stage |
| commit_stall_i | input | 1 | Stall from commit |
| squash_i | input | 1 | Squash request from commit |
| out_cnt_o | output | 3 | Number of tags sent this cycle |
| out_tag_o | output | 24 | Packed sent tags, slot 0 first |
| dec_stall_o | output | 1 | Stall to decode |
| state_o | output | 3 | Stage state code |

## Verification
Every result comes from a single register stage. Inputs are applied at a falling clock edge, and the count, tags, stall and state they produce are due at the next rising edge. The bench therefore compares them at the falling edge that follows. A multi-step effect spans several such cycles: block, then the unblock decision, then the resume from the skid buffer. The bench checks it one cycle at a time, applying each cycle's stimulus only after the previous cycle's outputs have been checked. A behavioural model built on a queue predicts every cycle's outputs, and directed sequences with hand-computed values pin down the boundary cases.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam int RFC_W  = 4;
    localparam int TAG_W  = 6;
    localparam int DST_W  = 2;
    localparam int GCNT_W = $clog2(RFC_W + 1);
    localparam int IDX_W  = (RFC_W > 1) ? $clog2(RFC_W) : 1;

    typedef struct packed {
        logic             sq;
        logic             ser;
        logic [DST_W-1:0] dst;
        logic [TAG_W-1:0] tag;
    } rfc_slot_t;

    typedef struct packed {
        logic [GCNT_W-1:0]        cnt;
        rfc_slot_t [RFC_W-1:0]    slot;
    } rfc_group_t;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_BLOCKED = 3'd1,
        ST_UNBLOCK = 3'd2,
        ST_BARRIER = 3'd3,
        ST_SQUASH  = 3'd4
    } rfc_state_e;

    typedef struct packed {
        rfc_state_e              st;
        logic [GCNT_W-1:0]       off;
        logic [GCNT_W-1:0]       ocnt;
        logic [RFC_W*TAG_W-1:0]  otag;
        logic                    stall;
    } rfc_regs_t;

endpackage

// File: rtl/rfc_skid_fifo.sv
module rfc_skid_fifo
    import rfc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  rfc_group_t push_grp,
    input  logic       pop,
    output rfc_group_t front,
    output logic       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    rfc_group_t mem [DEPTH];
    logic [PTR_W-1:0] rd_d, rd_q, wr_d, wr_q;
    logic [LVL_W-1:0] lvl_d, lvl_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_d  = rd_q;
        wr_d  = wr_q;
        lvl_d = lvl_q;
        if (clr) begin
            rd_d  = '0;
            wr_d  = '0;
            lvl_d = '0;
        end else begin
            if (pop)  rd_d = bump(rd_q);
            if (push) wr_d = bump(wr_q);
            lvl_d = lvl_q + LVL_W'(push) - LVL_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            lvl_q <= '0;
        end else begin
            rd_q  <= rd_d;
            wr_q  <= wr_d;
            lvl_q <= lvl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wr_q] <= push_grp;
    end

    assign front = mem[rd_q];
    assign full  = (int'(lvl_q) == DEPTH);
    assign level = lvl_q;

endmodule

// File: rtl/rfc_budget.sv
module rfc_budget
    import rfc_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int DLY    = 1
) (
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    output logic              room_ok,
    output logic              both_pos,
    output logic [GCNT_W-1:0] room_cap
);
    localparam int SW      = FREE_W + 2;
    localparam int RESERVE = RFC_W * DLY;

    logic signed [SW-1:0] rob_u, iq_u, least;

    always_comb begin
        rob_u    = $signed({2'b00, rob_free}) - $signed(SW'(RESERVE));
        iq_u     = $signed({2'b00, iq_free})  - $signed(SW'(RESERVE));
        least    = (rob_u < iq_u) ? rob_u : iq_u;
        room_ok  = (least > 0);
        both_pos = (rob_u > 0) && (iq_u > 0);
        if (least >= $signed(SW'(RFC_W))) room_cap = GCNT_W'(RFC_W);
        else if (least <= 0)              room_cap = '0;
        else                              room_cap = GCNT_W'(least);
    end

endmodule

// File: rtl/rfc_group_eval.sv
module rfc_group_eval
    import rfc_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  rfc_slot_t [RFC_W-1:0]   slots,
    input  logic [GCNT_W-1:0]       start_off,
    input  logic [GCNT_W-1:0]       limit,
    input  logic [FREE_W-1:0]       prf_free,
    output logic [GCNT_W-1:0]       sent,
    output logic [RFC_W*TAG_W-1:0]  tags,
    output logic [GCNT_W-1:0]       end_off,
    output logic                    stop_prf,
    output logic                    stop_ser
);
    always_comb begin
        int pos;
        int left;
        int nsent;
        logic done;
        logic [IDX_W-1:0] sel;
        rfc_slot_t cur;
        pos      = int'(start_off);
        left     = int'(prf_free);
        nsent    = 0;
        done     = 1'b0;
        tags     = '0;
        stop_prf = 1'b0;
        stop_ser = 1'b0;
        sel      = '0;
        cur      = '0;
        for (int k = 0; k < RFC_W; k++) begin
            if (!done && k < int'(limit) && pos < RFC_W) begin
                sel = IDX_W'(pos);
                cur = slots[sel];
                if (cur.sq) begin
                    pos = pos + 1;
                end else if (left < int'(cur.dst)) begin
                    stop_prf = 1'b1;
                    done     = 1'b1;
                end else begin
                    tags[nsent*TAG_W +: TAG_W] = cur.tag;
                    nsent = nsent + 1;
                    left  = left - int'(cur.dst);
                    pos   = pos + 1;
                    if (cur.ser) begin
                        stop_ser = 1'b1;
                        done     = 1'b1;
                    end
                end
            end
        end
        sent    = GCNT_W'(nsent);
        end_off = GCNT_W'(pos);
    end

endmodule

// File: rtl/rename_flow_ctrl.sv
module rename_flow_ctrl
    import rfc_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int DLY    = 1,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GCNT_W-1:0]       dec_cnt_i,
    input  logic [RFC_W*TAG_W-1:0]  dec_tag_i,
    input  logic [RFC_W-1:0]        dec_squashed_i,
    input  logic [RFC_W-1:0]        dec_serial_i,
    input  logic [RFC_W*DST_W-1:0]  dec_dst_i,
    input  logic [FREE_W-1:0]       rob_free_i,
    input  logic [FREE_W-1:0]       iq_free_i,
    input  logic [FREE_W-1:0]       prf_free_i,
    input  logic                    iew_stall_i,
    input  logic                    commit_stall_i,
    input  logic                    squash_i,
    output logic [GCNT_W-1:0]       out_cnt_o,
    output logic [RFC_W*TAG_W-1:0]  out_tag_o,
    output logic                    dec_stall_o,
    output logic [2:0]              state_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    rfc_regs_t  r_d, r_q;
    rfc_group_t dec_grp, skid_front, src;
    logic       skid_push, skid_pop, skid_clr, skid_full;
    logic [LVL_W-1:0] skid_level;

    logic              room_ok, both_pos;
    logic [GCNT_W-1:0] room_cap, avail, limit, sent, end_off;
    logic [RFC_W*TAG_W-1:0] tags;
    logic              stop_prf, stop_ser, lim_blk, use_skid;

    always_comb begin
        dec_grp.cnt = dec_cnt_i;
        for (int i = 0; i < RFC_W; i++) begin
            dec_grp.slot[i].tag = dec_tag_i[i*TAG_W +: TAG_W];
            dec_grp.slot[i].dst = dec_dst_i[i*DST_W +: DST_W];
            dec_grp.slot[i].sq  = dec_squashed_i[i];
            dec_grp.slot[i].ser = dec_serial_i[i];
        end
    end

    rfc_budget #(.FREE_W(FREE_W), .DLY(DLY)) u_budget (
        .rob_free (rob_free_i),
        .iq_free  (iq_free_i),
        .room_ok  (room_ok),
        .both_pos (both_pos),
        .room_cap (room_cap)
    );

    assign use_skid = (r_q.st == ST_UNBLOCK);
    assign src      = use_skid ? skid_front : dec_grp;
    assign avail    = (src.cnt > r_q.off) ? (src.cnt - r_q.off) : '0;

    always_comb begin
        lim_blk = 1'b0;
        limit   = avail;
        if (!room_ok) begin
            limit   = '0;
            lim_blk = 1'b1;
        end else if (room_cap < avail) begin
            limit   = room_cap;
            lim_blk = 1'b1;
        end
    end

    rfc_group_eval #(.FREE_W(FREE_W)) u_eval (
        .slots     (src.slot),
        .start_off (r_q.off),
        .limit     (limit),
        .prf_free  (prf_free_i),
        .sent      (sent),
        .tags      (tags),
        .end_off   (end_off),
        .stop_prf  (stop_prf),
        .stop_ser  (stop_ser)
    );

    rfc_skid_fifo #(.DEPTH(DEPTH)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (skid_clr),
        .push     (skid_push),
        .push_grp (dec_grp),
        .pop      (skid_pop),
        .front    (skid_front),
        .full     (skid_full),
        .level    (skid_level)
    );

    always_comb begin
        logic blk;
        logic has_in;
        r_d       = r_q;
        r_d.ocnt  = '0;
        r_d.otag  = '0;
        skid_push = 1'b0;
        skid_pop  = 1'b0;
        skid_clr  = 1'b0;
        has_in    = (dec_cnt_i != '0);
        blk       = lim_blk | stop_prf | stop_ser;
        if (squash_i) begin
            r_d.st   = ST_SQUASH;
            r_d.off  = '0;
            skid_clr = 1'b1;
        end else if (r_q.st == ST_BLOCKED || r_q.st == ST_BARRIER) begin
            skid_push = has_in;
            if (!iew_stall_i && !commit_stall_i && both_pos && prf_free_i != '0)
                r_d.st = ST_UNBLOCK;
        end else if (!use_skid && !has_in) begin
            r_d.st = ST_RUN;
        end else begin
            r_d.ocnt = sent;
            r_d.otag = tags;
            if (blk) begin
                r_d.st    = stop_ser ? ST_BARRIER : ST_BLOCKED;
                r_d.off   = end_off;
                skid_push = use_skid ? has_in : 1'b1;
            end else begin
                r_d.off = '0;
                if (use_skid) begin
                    skid_pop  = 1'b1;
                    skid_push = has_in;
                    r_d.st    = (skid_level == LVL_W'(1) && !has_in) ? ST_RUN : ST_UNBLOCK;
                end else begin
                    r_d.st = ST_RUN;
                end
            end
        end
        r_d.stall = (r_d.st == ST_BLOCKED) || (r_d.st == ST_BARRIER) ||
                    (r_d.st == ST_UNBLOCK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, off: '0, ocnt: '0, otag: '0, stall: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_cnt_o   = r_q.ocnt;
    assign out_tag_o   = r_q.otag;
    assign dec_stall_o = r_q.stall;
    assign state_o     = r_q.st;

endmodule

// File: rtl/rfc_chk.sv
module rfc_chk
    import rfc_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int DLY    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              squash_i,
    input logic              iew_stall_i,
    input logic              commit_stall_i,
    input logic [FREE_W-1:0] rob_free_i,
    input logic [2:0]        state_o,
    input logic [GCNT_W-1:0] out_cnt_o,
    input logic              dec_stall_o,
    input logic              skid_push,
    input logic              skid_pop,
    input logic              skid_full
);
    // R11
    squash_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> (state_o == 3'd4 && out_cnt_o == '0 && !dec_stall_o));

    // R8
    blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 || state_o == 3'd3) |=> (out_cnt_o == '0));

    // R2
    rob_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rob_free_i) <= RFC_W * DLY) |=> (out_cnt_o == '0));

    // R9
    unblock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && (iew_stall_i || commit_stall_i) && !squash_i)
        |=> (state_o == 3'd1));

    // R12
    stall_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall_o |-> (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd3));

    // R13
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_push && !skid_pop) |-> !skid_full);

endmodule

bind rename_flow_ctrl rfc_chk #(.FREE_W(FREE_W), .DLY(DLY)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .squash_i       (squash_i),
    .iew_stall_i    (iew_stall_i),
    .commit_stall_i (commit_stall_i),
    .rob_free_i     (rob_free_i),
    .state_o        (state_o),
    .out_cnt_o      (out_cnt_o),
    .dec_stall_o    (dec_stall_o),
    .skid_push      (skid_push),
    .skid_pop       (skid_pop),
    .skid_full      (skid_full)
);

// File: tb/sim_rename_flow_ctrl.sv
`timescale 1ns/1ps
module sim_rename_flow_ctrl;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic [2:0]  dec_cnt_i;
    logic [23:0] dec_tag_i;
    logic [3:0]  dec_squashed_i, dec_serial_i;
    logic [7:0]  dec_dst_i;
    logic [7:0]  rob_free_i, iq_free_i, prf_free_i;
    logic        iew_stall_i, commit_stall_i, squash_i;
    logic [2:0]  out_cnt_o;
    logic [23:0] out_tag_o;
    logic        dec_stall_o;
    logic [2:0]  state_o;

    rename_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .dec_cnt_i(dec_cnt_i), .dec_tag_i(dec_tag_i),
        .dec_squashed_i(dec_squashed_i), .dec_serial_i(dec_serial_i),
        .dec_dst_i(dec_dst_i), .rob_free_i(rob_free_i), .iq_free_i(iq_free_i),
        .prf_free_i(prf_free_i), .iew_stall_i(iew_stall_i),
        .commit_stall_i(commit_stall_i), .squash_i(squash_i),
        .out_cnt_o(out_cnt_o), .out_tag_o(out_tag_o),
        .dec_stall_o(dec_stall_o), .state_o(state_o)
    );

    typedef struct packed {
        logic [2:0]      n;
        logic [3:0]      sq;
        logic [3:0]      se;
        logic [3:0][1:0] ds;
        logic [3:0][5:0] tg;
    } bgrp_t;

    bgrp_t cur;
    bgrp_t skq[$];
    int m_st, m_off, e_cnt, e_stall;
    int e_tag[4];
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic void model_step();
        bgrp_t g;
        int was, ravail, m, lim, pos, left, sent, ru, iu;
        bit blk, ser;
        for (int i = 0; i < 4; i++) e_tag[i] = 0;
        e_cnt = 0;
        was = m_st;
        ru = int'(rob_free_i) - 4;
        iu = int'(iq_free_i) - 4;
        if (squash_i) begin
            skq.delete();
            m_off = 0;
            m_st = 4;
        end else if (was == 1 || was == 3) begin
            if (cur.n != 0) skq.push_back(cur);
            if (!iew_stall_i && !commit_stall_i && ru > 0 && iu > 0 && prf_free_i != 0)
                m_st = 2;
        end else if (was != 2 && cur.n == 0) begin
            m_st = 0;
        end else begin
            g = (was == 2) ? skq[0] : cur;
            ravail = int'(g.n) - m_off;
            m = (ru < iu) ? ru : iu;
            blk = 0; ser = 0; lim = ravail;
            if (m <= 0) begin blk = 1; lim = 0; end
            else if (m < ravail) begin lim = m; blk = 1; end
            pos = m_off; left = int'(prf_free_i); sent = 0;
            for (int k = 0; k < lim; k++) begin
                if (g.sq[pos]) begin pos++; continue; end
                if (left < int'(g.ds[pos])) begin blk = 1; break; end
                e_tag[sent] = int'(g.tg[pos]);
                sent++;
                left -= int'(g.ds[pos]);
                pos++;
                if (g.se[pos-1]) begin ser = 1; blk = 1; break; end
            end
            e_cnt = sent;
            if (blk) begin
                m_st = ser ? 3 : 1;
                m_off = pos;
                if (was != 2 || cur.n != 0) skq.push_back(cur);
            end else begin
                m_off = 0;
                if (was == 2) begin
                    void'(skq.pop_front());
                    if (cur.n != 0) skq.push_back(cur);
                    m_st = (skq.size() == 0) ? 0 : 2;
                end else m_st = 0;
            end
        end
        e_stall = (m_st >= 1 && m_st <= 3) ? 1 : 0;
    endfunction

    task automatic drive();
        dec_cnt_i = cur.n;
        dec_squashed_i = cur.sq;
        dec_serial_i = cur.se;
        for (int i = 0; i < 4; i++) begin
            dec_tag_i[i*6 +: 6] = cur.tg[i];
            dec_dst_i[i*2 +: 2] = cur.ds[i];
        end
    endtask

    // one clock: model predicts, edge, compare at following falling edge
    task automatic cyc();
        drive();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R4 count", int'(out_cnt_o), e_cnt);
        for (int i = 0; i < 4; i++) chk("R4 tag", int'(out_tag_o[i*6 +: 6]), e_tag[i]);
        chk("R12 stall", int'(dec_stall_o), e_stall);
        chk("R9 state", int'(state_o), m_st);
    endtask

    task automatic set_grp(int n, int base);
        cur = '0;
        cur.n = 3'(n);
        for (int i = 0; i < n; i++) begin
            cur.tg[i] = 6'(base + i);
            cur.ds[i] = 2'd1;
        end
    endtask

    task automatic res(int rob, int iq, int prf);
        rob_free_i = 8'(rob);
        iq_free_i = 8'(iq);
        prf_free_i = 8'(prf);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        rst_n = 0; cur = '0; squash_i = 0; iew_stall_i = 0; commit_stall_i = 0;
        res(20, 20, 20);
        drive();
        m_st = 0; m_off = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 count", int'(out_cnt_o), 0);
        chk("R1 stall", int'(dec_stall_o), 0);
        chk("R1 state", int'(state_o), 0);
        rst_n = 1;

        // R4 packing
        set_grp(3, 1); cyc();
        chk("R4 n", int'(out_cnt_o), 3);
        chk("R4 slot2", int'(out_tag_o[12 +: 6]), 3);
        // R5 squashed slot skipped
        set_grp(4, 10); cur.sq[1] = 1'b1; cyc();
        chk("R5 n", int'(out_cnt_o), 3);
        chk("R5 slot1", int'(out_tag_o[6 +: 6]), 12);
        // R2 no usable space
        res(4, 20, 20); set_grp(2, 20); cyc();
        chk("R2 n", int'(out_cnt_o), 0);
        chk("R2 state", int'(state_o), 1);
        cur = '0; cyc();
        res(20, 20, 20); iew_stall_i = 1; cyc();
        chk("R9 held", int'(state_o), 1);
        iew_stall_i = 0; cyc();
        chk("R9 unblock", int'(state_o), 2);
        cyc();
        chk("R9 resume n", int'(out_cnt_o), 2);
        chk("R9 resume tag", int'(out_tag_o[0 +: 6]), 20);
        chk("R9 run", int'(state_o), 0);
        // R3 partial group
        res(6, 20, 20); set_grp(4, 30); cyc();
        chk("R3 n", int'(out_cnt_o), 2);
        chk("R3 state", int'(state_o), 1);
        cur = '0; res(20, 20, 20); cyc(); cyc();
        chk("R3 rest n", int'(out_cnt_o), 2);
        chk("R3 rest tag", int'(out_tag_o[0 +: 6]), 32);
        // R10 offset back to 0
        set_grp(2, 40); cyc();
        chk("R10 tag", int'(out_tag_o[0 +: 6]), 40);
        // R7 physical registers
        res(20, 20, 3); set_grp(3, 50); cur.ds[0] = 2'd2; cyc();
        chk("R7 n", int'(out_cnt_o), 2);
        chk("R7 state", int'(state_o), 1);
        cur = '0; res(20, 20, 20); cyc(); cyc();
        chk("R7 rest tag", int'(out_tag_o[0 +: 6]), 52);
        // R6 serializing
        set_grp(3, 60); cur.se[1] = 1'b1; cyc();
        chk("R6 n", int'(out_cnt_o), 2);
        chk("R6 state", int'(state_o), 3);
        // R8 group arriving while blocked is kept
        res(4, 20, 20); set_grp(1, 7); cyc();
        chk("R8 n", int'(out_cnt_o), 0);
        cur = '0; res(20, 20, 20); cyc(); cyc();
        chk("R6 rest tag", int'(out_tag_o[0 +: 6]), 62);
        cyc();
        chk("R8 kept tag", int'(out_tag_o[0 +: 6]), 7);
        chk("R8 run", int'(state_o), 0);
        // R11 squash
        res(4, 20, 20); set_grp(2, 16); cyc();
        squash_i = 1; cur = '0; cyc();
        chk("R11 state", int'(state_o), 4);
        chk("R11 stall", int'(dec_stall_o), 0);
        squash_i = 0; cyc();
        res(20, 20, 20); set_grp(1, 9); cyc();
        chk("R11 cleared tag", int'(out_tag_o[0 +: 6]), 9);
        chk("R11 cleared state", int'(state_o), 0);

        // mixed traffic, decode honours the stall
        for (int t = 0; t < 4000; t++) begin
            cur = '0;
            if (!dec_stall_o) begin
                cur.n = 3'($urandom_range(0, 4));
                for (int i = 0; i < 4; i++) begin
                    cur.tg[i] = 6'($urandom_range(1, 63));
                    cur.ds[i] = 2'($urandom_range(0, 3));
                    cur.sq[i] = ($urandom_range(0, 7) == 0);
                    cur.se[i] = ($urandom_range(0, 9) == 0);
                end
            end
            res($urandom_range(0, 14), $urandom_range(0, 14), $urandom_range(0, 8));
            iew_stall_i = ($urandom_range(0, 5) == 0);
            commit_stall_i = ($urandom_range(0, 5) == 0);
            squash_i = ($urandom_range(0, 39) == 0);
            cyc();
        end
        summary();
    end

endmodule